// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block holds the status byte of a serial nonvolatile memory: the write-enable latch, two block-protect level bits and a lock-enable bit. It also decides, in the same cycle, whether a write request from the command front end is granted or denied. There are two kinds of request. An array write carries a byte address. A status write carries a new status byte. The front end also drives set and clear requests for the write-enable latch. A programming engine reports its work through a busy level and a one-cycle completion pulse.

The array is divided into quarters by the two most significant address bits. The protect level shields nothing, the top quarter, the top half or the whole array. An active-low lock pin, when the lock-enable bit is 1, freezes the status register. A status write does not take effect at once. The new bits are held pending and committed when the programming cycle completes. While any cycle is in flight, the status byte reads as all ones. Retention across power loss is outside this block. At reset the protection bits take the value of a parameter.

Top module: `wpg_status_guard`

## Requirements
- R1: When no cycle is in flight, `status_byte` is {lock_en, 3'b000, lvl[1], lvl[0], wel, 1'b0}. The bit positions are 7 for lock_en, 6 to 4 reading zero, 3 for lvl[1], 2 for lvl[0], 1 for the write-enable latch, and 0 as the busy flag.
- R2: While `eng_busy` is 1, or a granted cycle has not yet seen `cyc_done`, `status_byte` is 8'hFF.
- R3: `wel_set` sets the latch at the next edge. `wel_clr` clears it. When both are asserted in the same cycle, the clear wins.
- R4: An array request is answered in its own cycle by exactly one of `arr_wr_grant` or `arr_wr_deny`. It is granted only when wel is 1, nothing is in flight, and the address is outside the protected range.
- R5: The protected range is set by lvl as follows. 00 protects nothing. 01 protects addresses whose two top bits are 11. 10 protects addresses whose top bit is 1. 11 protects every address. With ADDR_W=15 these ranges are 0x6000–0x7FFF, 0x4000–0x7FFF and the whole array.
- R6: The hardware lock is active only when `lock_pin_n` is 0 and lock_en is 1. While it is active, every status request is denied. Otherwise a status request is granted when wel is 1 and nothing is in flight.
- R7: A granted status write takes only data bits 7, 3 and 2, into lock_en, lvl[1] and lvl[0]. They become visible after the `cyc_done` pulse that ends its cycle, and all other data bits are dropped.
- R8: wel reads 0 after any denied request, and after the completion of a granted cycle.
- R9: After reset, wel is 0, nothing is in flight, and {lock_en, lvl} equals the parameter NV_RESET.
- R10: A request that arrives while a cycle is in flight is denied, even when wel is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_pin_n | input | 1 | Active-low hardware lock pin |
| wel_set | input | 1 | Set the write-enable latch |
| wel_clr | input | 1 | Clear the write-enable latch |
| arr_wr_req | input | 1 | Array write request (one cycle) |
| arr_wr_addr | input | ADDR_W | Array byte address of the request |
| sts_wr_req | input | 1 | Status write request (one cycle) |
| sts_wr_data | input | 8 | New status byte |
| eng_busy | input | 1 | Programming engine is busy |
| cyc_done | input | 1 | Programming cycle completes (pulse) |
| status_byte | output | 8 | Status byte to be shifted out |
| arr_wr_grant | output | 1 | Array request allowed |
| arr_wr_deny | output | 1 | Array request refused |
| sts_wr_grant | output | 1 | Status request allowed |
| sts_wr_deny | output | 1 | Status request refused |

## Verification
The case hardest to reach from the ports is a request that meets a hardware lock which a status write has only just enabled. Reaching it takes a whole sequence: set wel, issue a status write that sets lock_en, let the emulated engine run through to `cyc_done`, drop the lock pin, set wel again, and only then issue the request. The bench drives this order with directed steps. It then walks each protect level across its boundary addresses, and issues a request while the engine is still busy with wel still 1. After that, seeded random traffic mixes every request type with random pin levels and addresses. The bench's own engine model answers each grant with a busy window and a completion pulse, and every output is compared each cycle with a reference model.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
   // status bit positions (a serial front end decodes these)
   localparam int unsigned SB_BUSY = 0;
   localparam int unsigned SB_WEL  = 1;
   localparam int unsigned SB_LVL0 = 2;
   localparam int unsigned SB_LVL1 = 3;
   localparam int unsigned SB_LOCK = 7;
   localparam int unsigned SB_W    = 8;

   typedef struct packed {
      logic       lock_en;
      logic [1:0] lvl;
   } nv_bits_t;

   function automatic nv_bits_t extract_nv(input logic [SB_W-1:0] d);
      nv_bits_t r;
      r.lock_en = d[SB_LOCK];
      r.lvl     = {d[SB_LVL1], d[SB_LVL0]};
      return r;
   endfunction
endpackage

// File: rtl/wpg_range_chk.sv
module wpg_range_chk #(
   parameter int unsigned ADDR_W = 15
) (
   input  logic [1:0]        lvl,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int unsigned TOP = ADDR_W - 1;

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("wpg_range_chk: ADDR_W must be at least 2");
      end
   endgenerate

   logic [1:0] quarter;
   assign quarter = addr[TOP -: 2];

   always_comb begin
      unique case (lvl)
         2'b00:   hit = 1'b0;
         2'b01:   hit = (quarter == 2'b11);
         2'b10:   hit = quarter[1];
         default: hit = 1'b1;
      endcase
   end
endmodule

// File: rtl/wpg_wel_latch.sv
module wpg_wel_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic wel_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wel_q <= 1'b0;
      else if (clr_i) wel_q <= 1'b0;
      else if (set_i) wel_q <= 1'b1;
   end

   // R3
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !wel_q);
   // R3
   set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !clr_i) |=> wel_q);
endmodule

// File: rtl/wpg_nv_bits.sv
module wpg_nv_bits
   import wpg_pkg::*;
#(
   parameter logic [2:0] NV_RESET = 3'b000
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     take_i,
   input  nv_bits_t din_i,
   input  logic     commit_i,
   output nv_bits_t nv_q
);
   nv_bits_t pend_val;
   logic     pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv_q     <= nv_bits_t'(NV_RESET);
         pend_val <= '0;
         pend_q   <= 1'b0;
      end else begin
         if (take_i) begin
            pend_val <= din_i;
            pend_q   <= 1'b1;
         end else if (commit_i) begin
            pend_q <= 1'b0;
            if (pend_q) nv_q <= pend_val;
         end
      end
   end

   // R7
   nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_i && pend_q) |=> $stable(nv_q));
endmodule

// File: rtl/wpg_status_guard.sv
module wpg_status_guard
   import wpg_pkg::*;
#(
   parameter int unsigned ADDR_W   = 15,
   parameter logic [2:0]  NV_RESET = 3'b000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_pin_n,
   input  logic              wel_set,
   input  logic              wel_clr,
   input  logic              arr_wr_req,
   input  logic [ADDR_W-1:0] arr_wr_addr,
   input  logic              sts_wr_req,
   input  logic [SB_W-1:0]   sts_wr_data,
   input  logic              eng_busy,
   input  logic              cyc_done,
   output logic [SB_W-1:0]   status_byte,
   output logic              arr_wr_grant,
   output logic              arr_wr_deny,
   output logic              sts_wr_grant,
   output logic              sts_wr_deny
);
   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr
         $error("wpg_status_guard: ADDR_W out of range");
      end
   endgenerate

   nv_bits_t nv;
   logic     wel;
   logic     inflight_q;
   logic     busy_any;
   logic     hw_lock;
   logic     in_range;
   logic     finish;
   logic     wel_drop;

   assign busy_any = eng_busy | inflight_q;
   assign hw_lock  = !lock_pin_n && nv.lock_en;
   assign finish   = cyc_done && inflight_q;

   wpg_range_chk #(.ADDR_W(ADDR_W)) u_range (
      .lvl  (nv.lvl),
      .addr (arr_wr_addr),
      .hit  (in_range)
   );

   assign arr_wr_grant = arr_wr_req && wel && !busy_any && !in_range;
   assign arr_wr_deny  = arr_wr_req && !arr_wr_grant;
   assign sts_wr_grant = sts_wr_req && wel && !busy_any && !hw_lock;
   assign sts_wr_deny  = sts_wr_req && !sts_wr_grant;

   assign wel_drop = wel_clr || arr_wr_deny || sts_wr_deny || finish;

   wpg_wel_latch u_wel (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (wel_set),
      .clr_i (wel_drop),
      .wel_q (wel)
   );

   wpg_nv_bits #(.NV_RESET(NV_RESET)) u_nv (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_i   (sts_wr_grant),
      .din_i    (extract_nv(sts_wr_data)),
      .commit_i (finish),
      .nv_q     (nv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             inflight_q <= 1'b0;
      else if (arr_wr_grant || sts_wr_grant)  inflight_q <= 1'b1;
      else if (cyc_done)                      inflight_q <= 1'b0;
   end

   always_comb begin
      status_byte = '0;
      if (busy_any) begin
         status_byte = '1;
      end else begin
         status_byte[SB_LOCK] = nv.lock_en;
         status_byte[SB_LVL1] = nv.lvl[1];
         status_byte[SB_LVL0] = nv.lvl[0];
         status_byte[SB_WEL]  = wel;
      end
   end

   // R2
   busy_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> (status_byte == 8'hFF));
   // R4
   arr_one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr_req |-> (arr_wr_grant != arr_wr_deny));
   // R5
   all_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_wr_req && nv.lvl == 2'b11) |-> !arr_wr_grant);
   // R6
   hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr_req && !lock_pin_n && nv.lock_en) |-> sts_wr_deny);
   // R8
   deny_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_wr_deny || sts_wr_deny) |=> !wel);
   // R10
   busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && (arr_wr_req || sts_wr_req)) |-> !(arr_wr_grant || sts_wr_grant));
endmodule

// File: tb/tb_wpg_status_guard.sv
module tb_wpg_status_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lock_pin_n = 1'b1, wel_set = 1'b0, wel_clr = 1'b0;
   logic        arr_wr_req = 1'b0, sts_wr_req = 1'b0;
   logic [14:0] arr_wr_addr = '0;
   logic [7:0]  sts_wr_data = '0;
   logic        eng_busy = 1'b0, cyc_done = 1'b0;
   logic [7:0]  status_byte;
   logic        arr_wr_grant, arr_wr_deny, sts_wr_grant, sts_wr_deny;

   int compared = 0;
   int mismatched = 0;

   // reference model state
   logic       m_wel = 0, m_lock = 0, m_infl = 0, m_pend = 0;
   logic [1:0] m_lvl = 0;
   logic [2:0] m_pv = 0;
   int         eng = 0;

   always #4 clk = ~clk;

   wpg_status_guard #(.ADDR_W(15), .NV_RESET(3'b000)) dut (.*);

   function automatic logic prot_hit(input logic [1:0] lv, input logic [14:0] a);
      case (lv)
         2'b00:   return 1'b0;
         2'b01:   return a[14:13] == 2'b11;
         2'b10:   return a[14];
         default: return 1'b1;
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(input string tag, input logic pn, input logic st, input logic cl,
                       input logic ar, input logic [14:0] ad, input logic sr, input logic [7:0] sd);
      logic busy, hw, a_ok, a_dn, s_ok, s_dn, fin;
      logic [7:0] exp_s;
      @(negedge clk);
      lock_pin_n = pn; wel_set = st; wel_clr = cl;
      arr_wr_req = ar; arr_wr_addr = ad; sts_wr_req = sr; sts_wr_data = sd;
      eng_busy = (eng != 0); cyc_done = (eng == 1);
      #2;
      busy = eng_busy | m_infl;
      hw   = !pn && m_lock;
      a_ok = ar && m_wel && !busy && !prot_hit(m_lvl, ad);
      a_dn = ar && !a_ok;
      s_ok = sr && m_wel && !busy && !hw;
      s_dn = sr && !s_ok;
      exp_s = busy ? 8'hFF : {m_lock, 3'b000, m_lvl, m_wel, 1'b0};
      chk(tag, "status", status_byte, exp_s);
      chk(tag, "arr grant/deny", {6'd0, arr_wr_grant, arr_wr_deny}, {6'd0, a_ok, a_dn});
      chk(tag, "sts grant/deny", {6'd0, sts_wr_grant, sts_wr_deny}, {6'd0, s_ok, s_dn});
      // model next state
      fin = cyc_done && m_infl;
      if (cl || a_dn || s_dn || fin) m_wel = 0;
      else if (st) m_wel = 1;
      if (s_ok) begin m_pend = 1; m_pv = {sd[7], sd[3], sd[2]}; end
      else if (cyc_done) begin
         if (m_pend) {m_lock, m_lvl} = m_pv;
         m_pend = 0;
      end
      if (a_ok || s_ok) m_infl = 1; else if (cyc_done) m_infl = 0;
      if (eng != 0) eng--;
      if (a_ok || s_ok) eng = 3;
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag, 1, 0, 0, 0, '0, 0, 8'h00);
   endtask

   task automatic sts_write(input string tag, input logic [7:0] d);
      step(tag, 1, 1, 0, 0, '0, 0, 8'h00);
      step(tag, 1, 0, 0, 0, '0, 1, d);
      idle(tag, 5);
   endtask

   initial begin
      #(8 * 200000);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      idle("R9", 1);
      // R3 set, then set and clear together
      step("R3", 1, 1, 0, 0, '0, 0, 8'h00);
      idle("R3", 1);
      step("R3", 1, 1, 1, 0, '0, 0, 8'h00);
      idle("R3", 1);
      // R7 only bits 7,3,2 taken; R2 reads FF while in flight; R8 wel dropped
      sts_write("R7", 8'hFF);
      idle("R8", 1);
      // R5 full protection, deny drops wel (R8)
      step("R5", 1, 1, 0, 0, '0, 0, 8'h00);
      step("R5", 1, 0, 0, 1, 15'h0000, 0, 8'h00);
      idle("R8", 1);
      // R6 hardware lock: pin low with lock_en=1
      step("R6", 0, 1, 0, 0, '0, 0, 8'h00);
      step("R6", 0, 0, 0, 0, '0, 1, 8'h04);
      idle("R6", 1);
      // R6 pin high releases the lock; set level 01
      sts_write("R6", 8'h04);
      // R5 top quarter boundary
      step("R5", 1, 1, 0, 0, '0, 0, 8'h00);
      step("R5", 1, 0, 0, 1, 15'h5FFF, 0, 8'h00);
      idle("R5", 5);
      step("R5", 1, 1, 0, 0, '0, 0, 8'h00);
      step("R5", 1, 0, 0, 1, 15'h6000, 0, 8'h00);
      // R5 top half boundary
      sts_write("R5", 8'h08);
      step("R5", 1, 1, 0, 0, '0, 0, 8'h00);
      step("R5", 1, 0, 0, 1, 15'h3FFF, 0, 8'h00);
      idle("R5", 5);
      step("R5", 1, 1, 0, 0, '0, 0, 8'h00);
      step("R5", 1, 0, 0, 1, 15'h4000, 0, 8'h00);
      // R10 request while busy with wel still 1
      step("R10", 1, 1, 0, 0, '0, 0, 8'h00);
      step("R10", 1, 0, 0, 1, 15'h0001, 0, 8'h00);
      step("R10", 1, 0, 0, 1, 15'h0002, 0, 8'h00);
      step("R10", 1, 0, 0, 0, '0, 1, 8'h00);
      idle("R10", 4);
      // R4 random traffic
      for (int i = 0; i < 3000; i++) begin
         step("R4", $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0,
              $urandom_range(0, 9) == 0, $urandom_range(0, 3) == 0,
              15'($urandom), $urandom_range(0, 5) == 0, 8'($urandom));
      end
      idle("R1", 6);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule